// File: doc/BRIEF.md
# FIFO Occupancy and DMA Request Controller

This block tracks how many bytes sit in the transmit and receive byte FIFOs of a serial port. It turns those counts into DMA request lines using trigger levels that software can program. The byte storage and the serial shift registers live elsewhere. This block only counts bytes, raises full and empty flags, and empties a FIFO's count on command. It never touches the shift registers.

The producer side of each FIFO pulses a push strobe for every byte it writes. The consumer side pulses a pop strobe for every byte it reads. The strobes are plain single-cycle controls. A push that arrives while a FIFO is full is simply not counted, so the storage owner must use the full flag to hold off its writer. A single 8-bit configuration word sets the trigger levels, the DMA enable, two self-clearing flush bits and the FIFO enable.

The receive request asks the DMA engine to drain the receive FIFO once enough bytes have gathered. The transmit request asks it to refill the transmit FIFO while too few bytes remain.

Top module: `fifo_dma_ctl`

## Requirements
- R1: After reset both levels are 0, both empty flags are 1, both full flags and both DMA requests are 0, and the enabled status is 00.
- R2: A push raises that FIFO's level by one and a pop lowers it by one; the new level is visible after the clock edge that samples the strobe.
- R3: A push to a FIFO holding DEPTH bytes is dropped; the level never exceeds DEPTH and the full flag is 1 exactly when the level equals DEPTH.
- R4: A pop from an empty FIFO is ignored; the empty flag is 1 exactly when the level is 0.
- R5: A push and a pop in the same cycle leave a non-empty FIFO's level unchanged, including when it is full; on an empty FIFO only the push counts.
- R6: The configuration word maps as follows: bit 0 is the FIFO enable, bit 1 the DMA enable, bit 2 the receive flush and bit 3 the transmit flush. Bits 5:4 hold the receive trigger code and bits 7:6 the transmit trigger code. Trigger code c selects a threshold of c+1 bytes, and every field takes effect from the clock edge that samples the write.
- R7: The receive DMA request is 1 while DMA is enabled and the receive level is at least the receive threshold.
- R8: The transmit DMA request is 1 while DMA is enabled and the transmit level is below the transmit threshold.
- R9: While the DMA enable is 0 both DMA requests are 0, whatever the levels.
- R10: Writing 1 to a flush bit zeroes only that FIFO's level. The flush bit self-clears after one cycle, so a later write with that bit at 0 leaves the level alone.
- R11: A write that changes the FIFO enable value zeroes both levels; a write that repeats the current value does not.
- R12: The enabled status reads 11 while the FIFO enable is 1 and 00 while it is 0.
- R13: The depth code output reads 0, 1, 2 or 3 for a DEPTH of 16, 32, 64 or 128 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word (layout in R6) |
| tx_push | input | 1 | Byte written into the transmit FIFO |
| tx_pop | input | 1 | Byte taken from the transmit FIFO |
| rx_push | input | 1 | Byte written into the receive FIFO |
| rx_pop | input | 1 | Byte taken from the receive FIFO |
| tx_level | output | $clog2(DEPTH+1) | Transmit FIFO occupancy |
| rx_level | output | $clog2(DEPTH+1) | Receive FIFO occupancy |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_dma_req | output | 1 | Transmit refill request |
| rx_dma_req | output | 1 | Receive drain request |
| fifo_en_stat | output | 2 | FIFOs-enabled status, 11 or 00 |
| depth_code | output | 2 | Encoded FIFO depth |

## Verification
Push and pop strobes move a level, and the flags and requests derived from it, one clock edge after the strobe. A configuration write changes the enables, the trigger levels and the status at the edge that samples it. A flush caused by a flush bit or an enable change lands one edge later, because the self-clearing pulse sits in a register. The bench drives every stimulus on a falling edge and samples on the next falling edge. After a configuration write it waits one extra falling edge before checking a flushed level, so every sample falls inside the cycle in which the result is due.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  // Configuration word, most significant field first.
  typedef struct packed {
    logic [1:0] tx_trig;
    logic [1:0] rx_trig;
    logic       tx_clr;
    logic       rx_clr;
    logic       dma_en;
    logic       fifo_en;
  } fdc_cfg_t;

  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
  localparam int NUM_CH = 2;

  function automatic logic [1:0] depth_to_code(input int depth);
    case (depth)
      16:      return 2'd0;
      32:      return 2'd1;
      64:      return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/fdc_cfg_reg.sv
module fdc_cfg_reg
  import fdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic       fifo_en,
  output logic       dma_en,
  output logic [1:0] tx_trig,
  output logic [1:0] rx_trig,
  output logic [NUM_CH-1:0] flush
);

  fdc_cfg_t wr;
  logic     toggle;

  assign wr     = fdc_cfg_t'(wdata);
  assign toggle = wr.fifo_en != fifo_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en <= 1'b0;
      dma_en  <= 1'b0;
      tx_trig <= '0;
      rx_trig <= '0;
      flush   <= '0;
    end else if (we) begin
      fifo_en       <= wr.fifo_en;
      dma_en        <= wr.dma_en;
      tx_trig       <= wr.tx_trig;
      rx_trig       <= wr.rx_trig;
      flush[CH_TX]  <= wr.tx_clr | toggle;
      flush[CH_RX]  <= wr.rx_clr | toggle;
    end else begin
      // Flush bits are one-cycle pulses: they clear themselves.
      flush <= '0;
    end
  end

endmodule

// File: rtl/fdc_level_ctr.sv
module fdc_level_ctr #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

  logic pop_ok, push_ok;

  assign full    = level == LVL_MAX;
  assign empty   = level == '0;
  assign pop_ok  = pop && !empty;
  // A full FIFO still takes a push when a byte leaves in the same cycle.
  assign push_ok = push && (!full || pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else if (flush) begin
      level <= '0;
    end else if (push_ok && !pop_ok) begin
      level <= level + 1'b1;
    end else if (pop_ok && !push_ok) begin
      level <= level - 1'b1;
    end
  end

endmodule

// File: rtl/fdc_dma_req.sv
module fdc_dma_req #(
  parameter int LVL_W = 5,
  parameter bit BELOW = 1'b0
) (
  input  logic             en,
  input  logic [1:0]       trig,
  input  logic [LVL_W-1:0] level,
  output logic             req
);

  logic [LVL_W-1:0] thr;

  assign thr = LVL_W'(trig) + LVL_W'(1);

  generate
    if (BELOW) begin : g_refill
      assign req = en && (level < thr);
    end else begin : g_drain
      assign req = en && (level >= thr);
    end
  endgenerate

endmodule

// File: rtl/fifo_dma_ctl.sv
module fifo_dma_ctl
  import fdc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  input  logic             tx_push,
  input  logic             tx_pop,
  input  logic             rx_push,
  input  logic             rx_pop,
  output logic [LVL_W-1:0] tx_level,
  output logic [LVL_W-1:0] rx_level,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             tx_dma_req,
  output logic             rx_dma_req,
  output logic [1:0]       fifo_en_stat,
  output logic [1:0]       depth_code
);

  logic              fifo_en_q;
  logic              dma_en_q;
  logic [1:0]        trig_q  [NUM_CH];
  logic [NUM_CH-1:0] flush_pulse;
  logic [NUM_CH-1:0] push_v, pop_v, full_v, empty_v, req_v;
  logic [LVL_W-1:0]  lvl_v   [NUM_CH];

  fdc_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .fifo_en (fifo_en_q),
    .dma_en  (dma_en_q),
    .tx_trig (trig_q[CH_TX]),
    .rx_trig (trig_q[CH_RX]),
    .flush   (flush_pulse)
  );

  assign push_v = {rx_push, tx_push};
  assign pop_v  = {rx_pop,  tx_pop};

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      fdc_level_ctr #(.DEPTH(DEPTH)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_pulse[ch]),
        .push  (push_v[ch]),
        .pop   (pop_v[ch]),
        .level (lvl_v[ch]),
        .full  (full_v[ch]),
        .empty (empty_v[ch])
      );

      fdc_dma_req #(.LVL_W(LVL_W), .BELOW(ch == CH_TX)) u_req (
        .en    (dma_en_q),
        .trig  (trig_q[ch]),
        .level (lvl_v[ch]),
        .req   (req_v[ch])
      );
    end
  endgenerate

  assign tx_level     = lvl_v[CH_TX];
  assign rx_level     = lvl_v[CH_RX];
  assign tx_full      = full_v[CH_TX];
  assign rx_full      = full_v[CH_RX];
  assign tx_empty     = empty_v[CH_TX];
  assign rx_empty     = empty_v[CH_RX];
  assign tx_dma_req   = req_v[CH_TX];
  assign rx_dma_req   = req_v[CH_RX];
  assign fifo_en_stat = {2{fifo_en_q}};
  assign depth_code   = depth_to_code(DEPTH);

endmodule

// File: rtl/fdc_checker.sv
module fdc_checker #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       flush,
  input logic             dma_en,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_full,
  input logic             tx_empty,
  input logic             rx_full,
  input logic             rx_empty,
  input logic             tx_dma_req,
  input logic             rx_dma_req,
  input logic [1:0]       fifo_en_stat
);

  initial begin
    a_depth_legal_r13: assert (DEPTH == 16 || DEPTH == 32 || DEPTH == 64 || DEPTH == 128);
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LVL_W'(DEPTH) && rx_level <= LVL_W'(DEPTH));

  p_full_not_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty));

  p_tx_flush_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush[0] |=> tx_level == '0);

  p_rx_flush_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush[1] |=> rx_level == '0);

  p_flush_selfclear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush != 2'b00 && !cfg_we) |=> flush == 2'b00);

  p_tx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flush[0] |=> (tx_level == $past(tx_level) || tx_level == $past(tx_level) + 1'b1
                   || tx_level == $past(tx_level) - 1'b1));

  p_rx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flush[1] |=> (rx_level == $past(rx_level) || rx_level == $past(rx_level) + 1'b1
                   || rx_level == $past(rx_level) - 1'b1));

  p_dma_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !tx_dma_req && !rx_dma_req);

  p_stat_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fifo_en_stat) != 1);

endmodule

bind fifo_dma_ctl fdc_checker #(.DEPTH(DEPTH)) u_fdc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .flush        (flush_pulse),
  .dma_en       (dma_en_q),
  .tx_level     (tx_level),
  .rx_level     (rx_level),
  .tx_full      (tx_full),
  .tx_empty     (tx_empty),
  .rx_full      (rx_full),
  .rx_empty     (rx_empty),
  .tx_dma_req   (tx_dma_req),
  .rx_dma_req   (rx_dma_req),
  .fifo_en_stat (fifo_en_stat)
);

// File: tb/fifo_dma_ctl_bench.sv
module fifo_dma_ctl_bench;

  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [7:0]       cfg_wdata;
  logic             tx_push, tx_pop, rx_push, rx_pop;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_dma_req, rx_dma_req;
  logic [1:0]       fifo_en_stat, depth_code;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  fifo_dma_ctl #(.DEPTH(DEPTH)) u_fifo_dma_ctl (
    .clk, .rst_n, .cfg_we, .cfg_wdata,
    .tx_push, .tx_pop, .rx_push, .rx_pop,
    .tx_level, .rx_level, .tx_full, .tx_empty, .rx_full, .rx_empty,
    .tx_dma_req, .rx_dma_req, .fifo_en_stat, .depth_code
  );

  // {tx_push, tx_pop, rx_push, rx_pop, expected tx level, expected rx level}
  localparam int NVEC = 10;
  localparam logic [19:0] VEC [NVEC] = '{
    {4'b1000, 8'd1, 8'd0},
    {4'b0010, 8'd1, 8'd1},
    {4'b1010, 8'd2, 8'd2},
    {4'b1001, 8'd3, 8'd1},
    {4'b1100, 8'd3, 8'd1},
    {4'b0001, 8'd3, 8'd0},
    {4'b0001, 8'd3, 8'd0},
    {4'b0011, 8'd3, 8'd1},
    {4'b0100, 8'd2, 8'd1},
    {4'b0110, 8'd1, 8'd2}
  };

  task automatic chk(input string tag, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic drive(input logic tp, input logic tpo, input logic rp, input logic rpo);
    tx_push = tp; tx_pop = tpo; rx_push = rp; rx_pop = rpo;
    @(negedge clk);
    tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 empties", {tx_empty, rx_empty}, 3);
    chk("R1 fulls", {tx_full, rx_full}, 0);
    chk("R1 requests", {tx_dma_req, rx_dma_req}, 0);
    chk("R1 status", fifo_en_stat, 0);
    chk("R13 depth code", depth_code, 0);

    // R2/R4/R5 table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16]);
      chk($sformatf("R2 R5 vec%0d tx", i), tx_level, VEC[i][15:8]);
      chk($sformatf("R2 R4 vec%0d rx", i), rx_level, VEC[i][7:0]);
    end

    // R11 and R12: enable change flushes both FIFOs
    cfg_write(8'h01);
    chk("R12 status on", fifo_en_stat, 3);
    @(negedge clk);
    chk("R11 toggle tx", tx_level, 0);
    chk("R11 toggle rx", rx_level, 0);
    drive(1, 0, 1, 0);
    drive(1, 0, 1, 0);
    cfg_write(8'h01);
    @(negedge clk);
    chk("R11 same value tx", tx_level, 2);
    chk("R11 same value rx", rx_level, 2);

    // R10: flush bit clears only its FIFO and self-clears
    cfg_write(8'h05);
    @(negedge clk);
    chk("R10 rx flushed", rx_level, 0);
    chk("R10 tx kept", tx_level, 2);
    drive(0, 0, 1, 0);
    cfg_write(8'h01);
    @(negedge clk);
    chk("R10 selfclear rx", rx_level, 1);

    // R6/R7/R8: rx threshold 3 (code 2), tx threshold 4 (code 3)
    cfg_write(8'hE3);
    chk("R8 tx req level2", tx_dma_req, 1);
    chk("R7 rx req level1", rx_dma_req, 0);
    drive(0, 0, 1, 0);
    chk("R7 rx req level2", rx_dma_req, 0);
    drive(0, 0, 1, 0);
    chk("R7 rx req level3", rx_dma_req, 1);
    drive(1, 0, 0, 0);
    chk("R8 tx req level3", tx_dma_req, 1);
    drive(1, 0, 0, 0);
    chk("R8 tx req level4", tx_dma_req, 0);

    // R9: DMA disabled gates both requests
    cfg_write(8'hE1);
    drive(0, 1, 0, 0);
    chk("R9 tx req off", tx_dma_req, 0);
    chk("R9 rx req off", rx_dma_req, 0);

    // R6: trigger code 0 means a 1-byte threshold
    cfg_write(8'h03);
    chk("R6 rx thr1", rx_dma_req, 1);
    chk("R6 tx thr1 level3", tx_dma_req, 0);
    drive(0, 1, 0, 0);
    drive(0, 1, 0, 0);
    chk("R6 tx thr1 level1", tx_dma_req, 0);
    drive(0, 1, 0, 0);
    chk("R6 tx thr1 level0", tx_dma_req, 1);

    // R3: fill past full, R5 at full
    for (int i = 0; i < DEPTH + 1; i++) drive(1, 0, 0, 0);
    chk("R3 full level", tx_level, DEPTH);
    chk("R3 full flag", tx_full, 1);
    drive(1, 0, 0, 0);
    chk("R3 dropped push", tx_level, DEPTH);
    drive(1, 1, 0, 0);
    chk("R5 push pop at full", tx_level, DEPTH);

    // R4: drain rx and pop past empty
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 1);
    chk("R4 rx level", rx_level, 0);
    chk("R4 rx empty", rx_empty, 1);

    finish_run();
  end

endmodule